// File: doc/BRIEF.md
# Half-Duplex Serial Character Transmitter

This block sends 8-bit characters over a single serial wire. A one-entry holding buffer accepts a character from a load strobe. When the transmitter is free it takes the character from the buffer and sends a frame on its output. The frame is a low start bit, the eight data bits, a parity bit, and one or two high stop bits. The bits go out either least significant first or most significant first. Parity can be set so that the total number of ones is even or odd. Every bit lasts a number of system clocks given at run time.

The block also shows what it is doing. `busy` covers the whole frame. `in_stop` covers only the stop bits. `drive_line` is high while the start, data and parity bits are on the wire. A wrapper around a shared bidirectional line uses `drive_line` to release the line as soon as the parity bit has gone out. Nothing has to drive the stop level, because the line rests high.

The sequencer has five states:
- IDLE: the line rests high.
- START: the start bit.
- DATA: the eight data bits.
- PARITY: the parity bit.
- STOP: one or two stop bits.

It moves between them as follows:
- IDLE→START when the buffer is full.
- START→DATA at the end of the bit.
- DATA→DATA after each data bit except the last.
- DATA→PARITY after the last data bit.
- PARITY→STOP at the end of the bit.
- STOP→STOP after the first of two stop bits.
- STOP→START after the last stop bit when the buffer is full.
- STOP→IDLE after the last stop bit when the buffer is empty.

Top module: `hdx_char_tx`

## Requirements
- R1: After the active-low asynchronous reset, `ser_out` is 1 and `busy`, `in_stop`, `drive_line` and `full` are 0.
- R2: A `load` pulse sampled while `full` is 0 stores `load_data`, and `full` reads 1 in the next cycle.
- R3: A `load` sampled while `full` is 1 is ignored: the stored character is not replaced, and no extra character is sent afterwards.
- R4: The frame starts in the cycle after `full` is first seen while idle, and `full` returns to 0 in that same cycle. Every bit lasts `cyc_per_bit` clocks, and a value of 0 counts as 1.
- R5: The start bit is 0. The stop bits are 1. `ser_out` is 1 while idle.
- R6: With `msb_first`=0 the data bits go out as b0 first up to b7. With `msb_first`=1 they go out as b7 first down to b0.
- R7: The parity bit follows the data. With `odd_par`=1 the data and parity together hold an odd number of ones. With `odd_par`=0 they hold an even number.
- R8: `two_stop`=1 gives two stop bits and `two_stop`=0 gives one.
- R9: `busy` is 1 from the first start-bit cycle to the last stop-bit cycle. `in_stop` is 1 exactly during the stop bits. `drive_line` equals `busy` AND NOT `in_stop`.
- R10: A character loaded during a frame starts right after the last stop bit, with no idle cycle between. `full` returns to 0 as that character starts.
- R11: `msb_first`, `odd_par`, `two_stop` and `cyc_per_bit` are captured when a character starts. Later changes affect only the characters that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_per_bit | input | CPB_W | Clocks per bit (0 treated as 1) |
| msb_first | input | 1 | 1: send b7 first, 0: send b0 first |
| odd_par | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| load | input | 1 | Write strobe for the holding buffer |
| load_data | input | CHAR_W | Character to write |
| full | output | 1 | Holding buffer has a character waiting |
| busy | output | 1 | A frame is on the line |
| in_stop | output | 1 | Stop bits are being sent |
| drive_line | output | 1 | Line must be driven (start, data, parity) |
| ser_out | output | 1 | Serial output |

## Verification
The bench builds the block with the default 8-bit character and a 16-bit bit-time field. Running at one clock per bit keeps each frame short. That makes it cheap to sweep all 256 data values against all eight combinations of bit order, parity sense and stop count, comparing the line level cycle by cycle. At two and three clocks per bit the bench checks bit widths and the zero-as-one rule. Back-to-back runs load a second character and a stray third one during a frame, and change the configuration in the middle of a frame.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    localparam logic LVL_START = 1'b0;
    localparam logic LVL_STOP  = 1'b1;

endpackage

// File: rtl/hdx_tx_hold.sv
module hdx_tx_hold #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] din,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] dout
);

    logic accept;
    assign accept = load && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (accept) begin
            full <= 1'b1;
            dout <= din;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assert_load_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !full) |=> full);

    assert_load_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full && !take) |=> (full && $stable(dout)));

endmodule

// File: rtl/hdx_tx_bittimer.sv
module hdx_tx_bittimer #(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CPB_W-1:0] cpb,
    output logic             bit_end
);

    logic [CPB_W-1:0] lim_r;
    logic [CPB_W-1:0] cnt;
    logic [CPB_W-1:0] lim_in;

    assign lim_in  = (cpb == '0) ? CPB_W'(1) : cpb;
    assign bit_end = run && (cnt == lim_r - CPB_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_r <= CPB_W'(1);
            cnt   <= '0;
        end else if (restart) begin
            lim_r <= lim_in;
            cnt   <= '0;
        end else if (!run || bit_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CPB_W'(1);
        end
    end

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim_r));

endmodule

// File: rtl/hdx_tx_framer.sv
module hdx_tx_framer
    import hdx_tx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              full,
    input  logic [CHAR_W-1:0] hold_data,
    input  logic              msb_first,
    input  logic              odd_par,
    input  logic              two_stop,
    output logic              take,
    output logic              ser_out,
    output logic              busy,
    output logic              in_stop
);

    localparam int IDX_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_W - 1);

    tx_state_e         state, state_nxt;
    logic [CHAR_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              par_r, msb_r, two_r, stop_second;
    logic              last_stop;

    assign last_stop = !two_r || stop_second;
    assign take = full && ((state == ST_IDLE) ||
                           (state == ST_STOP && bit_end && last_stop));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (full) state_nxt = ST_START;
            ST_START:  if (bit_end) state_nxt = ST_DATA;
            ST_DATA:   if (bit_end && idx == LAST_IDX) state_nxt = ST_PARITY;
            ST_PARITY: if (bit_end) state_nxt = ST_STOP;
            ST_STOP:   if (bit_end && last_stop) state_nxt = full ? ST_START : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            idx         <= '0;
            par_r       <= 1'b0;
            msb_r       <= 1'b0;
            two_r       <= 1'b0;
            stop_second <= 1'b0;
        end else if (take) begin
            shreg       <= hold_data;
            idx         <= '0;
            par_r       <= (^hold_data) ^ odd_par;
            msb_r       <= msb_first;
            two_r       <= two_stop;
            stop_second <= 1'b0;
        end else if (bit_end) begin
            if (state == ST_DATA) begin
                shreg <= msb_r ? (shreg << 1) : (shreg >> 1);
                idx   <= idx + IDX_W'(1);
            end
            if (state == ST_STOP) stop_second <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ser_out = LVL_STOP;
        busy    = 1'b1;
        in_stop = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_START:  ser_out = LVL_START;
            ST_DATA:   ser_out = msb_r ? shreg[CHAR_W-1] : shreg[0];
            ST_PARITY: ser_out = par_r;
            ST_STOP:   in_stop = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assert_start_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && !ser_out && !in_stop));

    assert_busy_ends_in_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(in_stop));

    assert_stop_follows_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_stop) |-> $past(state == ST_PARITY));

endmodule

// File: rtl/hdx_char_tx.sv
module hdx_char_tx #(
    parameter int CHAR_W = 8,
    parameter int CPB_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPB_W-1:0]  cyc_per_bit,
    input  logic              msb_first,
    input  logic              odd_par,
    input  logic              two_stop,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    output logic              full,
    output logic              busy,
    output logic              in_stop,
    output logic              drive_line,
    output logic              ser_out
);

    logic              take;
    logic              bit_end;
    logic [CHAR_W-1:0] hold_q;

    hdx_tx_hold #(.CHAR_W(CHAR_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (load_data),
        .take  (take),
        .full  (full),
        .dout  (hold_q)
    );

    hdx_tx_bittimer #(.CPB_W(CPB_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take),
        .run     (busy),
        .cpb     (cyc_per_bit),
        .bit_end (bit_end)
    );

    hdx_tx_framer #(.CHAR_W(CHAR_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_end   (bit_end),
        .full      (full),
        .hold_data (hold_q),
        .msb_first (msb_first),
        .odd_par   (odd_par),
        .two_stop  (two_stop),
        .take      (take),
        .ser_out   (ser_out),
        .busy      (busy),
        .in_stop   (in_stop)
    );

    assign drive_line = busy && !in_stop;

    assert_released_in_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_stop) |-> (!drive_line && ser_out));

endmodule

// File: tb/hdx_char_tx_bench.sv
module hdx_char_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cyc_per_bit = 16'd1;
    logic        msb_first = 1'b0, odd_par = 1'b0, two_stop = 1'b0;
    logic        load = 1'b0;
    logic [7:0]  load_data = 8'h00;
    logic        full, busy, in_stop, drive_line, ser_out;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    hdx_char_tx u_hdx_char_tx (
        .clk(clk), .rst_n(rst_n), .cyc_per_bit(cyc_per_bit),
        .msb_first(msb_first), .odd_par(odd_par), .two_stop(two_stop),
        .load(load), .load_data(load_data), .full(full), .busy(busy),
        .in_stop(in_stop), .drive_line(drive_line), .ser_out(ser_out)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // cfg = {two_stop, odd_par, msb_first}; returns the frame bit j
    function automatic logic fbit(input logic [7:0] d, input logic [2:0] cfg, input int j);
        if (j == 0) return 1'b0;
        if (j <= 8) return cfg[0] ? d[8 - j] : d[j - 1];
        if (j == 9) return (^d) ^ cfg[1];
        return 1'b1;
    endfunction

    function automatic string ftag(input int j);
        if (j == 0) return "R5 start";
        if (j <= 8) return "R6 data";
        if (j == 9) return "R7 parity";
        return "R8 stop";
    endfunction

    task automatic play(input int n, input logic [15:0] cpb, input logic [7:0] a,
                        input logic [2:0] ca, input bit two_chars,
                        input logic [7:0] b, input logic [2:0] cb);
        int len_a, len, iload;
        len_a = (11 + ca[2]) * n;
        len   = len_a + (two_chars ? (11 + cb[2]) * n : 0);
        iload = 2;
        @(negedge clk);
        cyc_per_bit = cpb;
        {two_stop, odd_par, msb_first} = ca;
        load_data = a;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R2 full after load", {7'd0, full}, 8'd1);
        chk("R4 not started yet", {7'd0, busy}, 8'd0);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            logic [2:0] c;
            int j;
            logic st;
            bit ef;
            @(negedge clk);
            if (i < len_a) begin d = a; c = ca; j = i / n; end
            else begin d = b; c = cb; j = (i - len_a) / n; end
            st = (j >= 10);
            chk(ftag(j), {4'd0, fbit(d, c, j), 1'b1, st, !st},
                {4'd0, ser_out, busy, in_stop, drive_line});
            ef = two_chars && (i >= iload + 1) && (i < len_a);
            chk(two_chars ? "R10 full while queued" : "R4 full cleared at start",
                {7'd0, full}, {7'd0, ef});
            if (two_chars && i == iload) begin
                {two_stop, odd_par, msb_first} = cb;
                load_data = b;
                load = 1'b1;
            end else if (two_chars && i == iload + 3) begin
                load_data = ~b;
                load = 1'b1;
            end else begin
                load = 1'b0;
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 idle after frame", {4'd0, ser_out, busy, in_stop, drive_line}, 8'b1000);
            chk("R3 stray load not kept", {7'd0, full}, 8'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [0:4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C; pats[4] = 8'h81;
        #5;
        chk("R1 reset outputs", {3'd0, ser_out, busy, in_stop, drive_line, full}, 8'b10000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 after release", {3'd0, ser_out, busy, in_stop, drive_line, full}, 8'b10000);
        // exhaustive sweep at one clock per bit
        for (int c = 0; c < 8; c++)
            for (int d = 0; d < 256; d++)
                play(1, 16'd1, 8'(d), 3'(c), 1'b0, 8'h00, 3'd0);
        // wider bit times
        for (int n = 2; n <= 3; n++)
            for (int c = 0; c < 8; c++)
                for (int p = 0; p < 5; p++)
                    play(n, 16'(n), pats[p], 3'(c), 1'b0, 8'h00, 3'd0);
        // zero bit time behaves as one (R4)
        play(1, 16'd0, 8'h96, 3'b010, 1'b0, 8'h00, 3'd0);
        // back-to-back with mid-frame config change (R10, R11, R3)
        for (int n = 1; n <= 3; n++)
            for (int c = 0; c < 8; c++)
                play(n, 16'(n), pats[(c + n) % 5], 3'(c), 1'b1, pats[(c + 2) % 5] ^ 8'h5A, 3'(7 - c));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule